// File: doc/BRIEF.md
# Hash Engine Command Sequence Checker

This block sits beside a keyed sponge-hash engine and watches the commands that software issues to it. A small phase machine follows the engine through its legal life cycle: idle, message feed, processing, absorbed and squeezing, plus a terminal error phase. The machine rejects commands that are not allowed in the current phase. On the single cycle where the engine leaves idle for message feed, it also checks the configuration that was latched for the job.

Each cycle the block reports at most one error code, chosen by a fixed priority. Some errors are blocking: once one is seen, the phase is frozen from the next cycle on until the error-processed input acknowledges it. An escalation input forces the terminal phase. A clear-after-error request returns the machine to idle.

Encodings used throughout:
- Commands (3 bits): 0 none, 1 start, 2 process, 3 run, 4 done. Codes 5 to 7 are unrecognised.
- Phases (3 bits): 0 idle, 1 feed, 2 processing, 3 absorbed, 4 squeezing, 5 terminal.
- Modes (2 bits): 0 fixed-length hash, 1 extendable output, 2 customisable extendable output. Mode 3 is not supported.
- Strengths (3 bits): 0 = 128, 1 = 224, 2 = 256, 3 = 384, 4 = 512. Codes 5 to 7 are not supported.
- Multi-bit flags (4 bits): 4'h6 is true and 4'h9 is false.
- Error codes (3 bits): 0 none, 1 sequence, 2 mode/strength, 3 prefix, 4 entropy.

Top module: `hseq_checker`

## Requirements
- R1: In the cycle after synchronous reset, the phase is idle (0), no error is reported, and both the block flag and the entropy-ready flag are clear.
- R2: Phase transitions follow a fixed set of rules.
  - From idle, start (1) moves to feed, but only while the application interface is inactive.
  - From feed, process (2) moves to processing.
  - From processing, the machine moves to absorbed only when the absorbed input equals 4'h6 exactly.
  - From absorbed, run (3) moves to squeezing and done (4) moves to idle.
  - From squeezing, the permutation-done input moves back to absorbed.
- R3: In idle, a start command while the application interface is active leaves the phase in idle and raises no error.
- R4: A command outside the allowed set for the current phase raises error code 1. The allowed sets are:
  - idle: {none, start}
  - feed: {none, process}
  - processing: {none}
  - absorbed: {none, run, done}
  - squeezing: {none}
- R5: On the idle-to-feed step, the mode and strength pair is checked. Mode 0 accepts strengths 224, 256, 384 and 512. Modes 1 and 2 accept 128 and 256. Any other pair raises error code 2, and the transition itself still happens.
- R6: On the idle-to-feed step with keyed mode enabled, a 48-bit prefix that differs from the expected value raises error code 3. A prefix error never blocks.
- R7: An entropy-ready pulse arriving in idle sets the entropy-ready flag from the next cycle, and error-processed clears it. A pulse outside idle is ignored. Entering feed in keyed mode while the flag is clear raises error code 4.
- R8: Certain errors set the block flag:
  - a sequence error;
  - an entropy error;
  - a mode/strength error while the allow-unsupported input is low.

  From the next cycle on, the phase holds until error-processed has been high for one cycle.
- R9: When several errors occur in the same cycle, the reported code follows the priority sequence, then mode/strength, then prefix, then entropy.
- R10: An escalation value other than 4'h9, with the block flag clear, moves the phase to terminal (5) on the next cycle. This applies from any phase.
- R11: A clear-after-error value of exactly 4'h6, without escalation and with the block flag clear, moves the phase to idle on the next cycle. This applies from any phase, including terminal. Any other value leaves terminal in place.
- R12: Error-valid is high in exactly the cycle in which an error is detected, and low with code 0 otherwise. It is not a held status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_i | input | 3 | Software command |
| app_active_i | input | 1 | Application interface busy |
| keyed_en_i | input | 1 | Keyed mode enabled |
| mode_i | input | 2 | Hash mode |
| strength_i | input | 3 | Security strength code |
| prefix_i | input | 48 | Keyed-mode encoded prefix |
| allow_unsup_i | input | 1 | Do not block on an unsupported mode/strength pair |
| ent_ready_pulse_i | input | 1 | Entropy-ready pulse |
| err_processed_i | input | 1 | Acknowledge of a pending error |
| absorbed_i | input | 4 | Absorb-complete status, multi-bit |
| perm_done_i | input | 1 | Permutation finished |
| escalate_i | input | 4 | Escalation, multi-bit |
| clear_err_i | input | 4 | Clear-after-error request, multi-bit |
| phase_o | output | 3 | Current phase |
| err_valid_o | output | 1 | Error detected this cycle |
| err_code_o | output | 3 | Prioritised error code |

## Verification
A wrong phase register shows up at the ports in the same cycle, because the sequence check depends on the phase. A legal command is then flagged as a sequence error, or an illegal one passes silently. A block flag that is stuck or never set shows one cycle after the error: the phase fails to freeze, or fails to advance after acknowledge. A stale entropy-ready flag surfaces only at the next keyed idle-to-feed step, so the bench places that step directly after the pulse and the acknowledge under test.

// File: rtl/hseq_pkg.sv
package hseq_pkg;

    typedef enum logic [2:0] {
        CMD_NONE    = 3'd0,
        CMD_START   = 3'd1,
        CMD_PROCESS = 3'd2,
        CMD_RUN     = 3'd3,
        CMD_DONE    = 3'd4
    } cmd_e;

    typedef enum logic [2:0] {
        PH_IDLE = 3'd0,
        PH_FEED = 3'd1,
        PH_PROC = 3'd2,
        PH_ABS  = 3'd3,
        PH_SQZ  = 3'd4,
        PH_TERM = 3'd5
    } phase_e;

    typedef enum logic [2:0] {
        ERR_NONE    = 3'd0,
        ERR_SEQ     = 3'd1,
        ERR_MODE    = 3'd2,
        ERR_PREFIX  = 3'd3,
        ERR_ENTROPY = 3'd4
    } err_code_e;

    localparam logic [1:0] MODE_FIXED = 2'd0;
    localparam logic [1:0] MODE_XOF   = 2'd1;
    localparam logic [1:0] MODE_CXOF  = 2'd2;

    localparam logic [2:0] STR_128 = 3'd0;
    localparam logic [2:0] STR_224 = 3'd1;
    localparam logic [2:0] STR_256 = 3'd2;
    localparam logic [2:0] STR_384 = 3'd3;
    localparam logic [2:0] STR_512 = 3'd4;

    localparam logic [3:0] MB_TRUE  = 4'h6;
    localparam logic [3:0] MB_FALSE = 4'h9;

    typedef struct packed {
        logic seq;
        logic mode;
        logic prefix;
        logic entropy;
    } err_set_t;

    function automatic logic mb_strict(input logic [3:0] v);
        return v == MB_TRUE;
    endfunction

    function automatic logic mb_loose(input logic [3:0] v);
        return v != MB_FALSE;
    endfunction

    function automatic logic pair_ok(input logic [1:0] m, input logic [2:0] s);
        logic fixed_ok;
        logic xof_ok;
        fixed_ok = (m == MODE_FIXED) &&
                   (s == STR_224 || s == STR_256 || s == STR_384 || s == STR_512);
        xof_ok   = (m == MODE_XOF || m == MODE_CXOF) &&
                   (s == STR_128 || s == STR_256);
        return fixed_ok || xof_ok;
    endfunction

endpackage

// File: rtl/hseq_phase_fsm.sv
module hseq_phase_fsm
    import hseq_pkg::*;
(
    input  phase_e      phase_q,
    input  logic [2:0]  cmd,
    input  logic        app_active,
    input  logic [3:0]  absorbed,
    input  logic        perm_done,
    input  logic [3:0]  escalate,
    input  logic [3:0]  clear_err,
    output phase_e      nxt,
    output logic        seq_err
);

    phase_e walk;

    // Per-phase command whitelist and legal moves
    always_comb begin
        walk    = phase_q;
        seq_err = 1'b0;
        case (phase_q)
            PH_IDLE: begin
                if (cmd == CMD_START && !app_active) walk = PH_FEED;
                seq_err = !(cmd == CMD_NONE || cmd == CMD_START);
            end
            PH_FEED: begin
                if (cmd == CMD_PROCESS) walk = PH_PROC;
                seq_err = !(cmd == CMD_NONE || cmd == CMD_PROCESS);
            end
            PH_PROC: begin
                if (mb_strict(absorbed)) walk = PH_ABS;
                seq_err = (cmd != CMD_NONE);
            end
            PH_ABS: begin
                if (cmd == CMD_RUN)       walk = PH_SQZ;
                else if (cmd == CMD_DONE) walk = PH_IDLE;
                seq_err = !(cmd == CMD_NONE || cmd == CMD_RUN || cmd == CMD_DONE);
            end
            PH_SQZ: begin
                if (perm_done) walk = PH_ABS;
                seq_err = (cmd != CMD_NONE);
            end
            PH_TERM: walk = PH_TERM;
            default: walk = PH_TERM;
        endcase
    end

    // Escalation wins over clear-after-error
    always_comb begin
        if (mb_loose(escalate))        nxt = PH_TERM;
        else if (mb_strict(clear_err)) nxt = PH_IDLE;
        else                           nxt = walk;
    end

endmodule

// File: rtl/hseq_cfg_check.sv
module hseq_cfg_check
    import hseq_pkg::*;
#(
    parameter int              PREFIX_W   = 48,
    parameter logic [PREFIX_W-1:0] EXP_PREFIX = 48'h4341_4D4B_2001
) (
    input  logic                enter,
    input  logic                keyed_en,
    input  logic [1:0]          mode,
    input  logic [2:0]          strength,
    input  logic [PREFIX_W-1:0] prefix,
    input  logic                ent_ok,
    output logic                mode_err,
    output logic                prefix_err,
    output logic                entropy_err
);

    logic keyed_enter;

    assign keyed_enter = enter && keyed_en;
    assign mode_err    = enter && !pair_ok(mode, strength);
    assign prefix_err  = keyed_enter && (prefix != EXP_PREFIX);
    assign entropy_err = keyed_enter && !ent_ok;

endmodule

// File: rtl/hseq_err_track.sv
module hseq_err_track
    import hseq_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  err_set_t  errs,
    input  logic      allow_unsup,
    input  logic      err_processed,
    input  logic      ready_pulse,
    input  logic      in_idle,
    output logic      blk_q,
    output logic      ent_q,
    output logic      err_valid,
    output err_code_e err_code
);

    logic blocking;

    assign blocking  = errs.seq || errs.entropy || (errs.mode && !allow_unsup);
    assign err_valid = |errs;

    always_comb begin
        if (errs.seq)          err_code = ERR_SEQ;
        else if (errs.mode)    err_code = ERR_MODE;
        else if (errs.prefix)  err_code = ERR_PREFIX;
        else if (errs.entropy) err_code = ERR_ENTROPY;
        else                   err_code = ERR_NONE;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            blk_q <= 1'b0;
            ent_q <= 1'b0;
        end else begin
            if (err_processed) blk_q <= 1'b0;
            else if (blocking) blk_q <= 1'b1;

            if (err_processed)               ent_q <= 1'b0;
            else if (ready_pulse && in_idle) ent_q <= 1'b1;
        end
    end

endmodule

// File: rtl/hseq_checker.sv
module hseq_checker
    import hseq_pkg::*;
#(
    parameter int                  PREFIX_W   = 48,
    parameter logic [PREFIX_W-1:0] EXP_PREFIX = 48'h4341_4D4B_2001
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [2:0]          cmd_i,
    input  logic                app_active_i,
    input  logic                keyed_en_i,
    input  logic [1:0]          mode_i,
    input  logic [2:0]          strength_i,
    input  logic [PREFIX_W-1:0] prefix_i,
    input  logic                allow_unsup_i,
    input  logic                ent_ready_pulse_i,
    input  logic                err_processed_i,
    input  logic [3:0]          absorbed_i,
    input  logic                perm_done_i,
    input  logic [3:0]          escalate_i,
    input  logic [3:0]          clear_err_i,
    output logic [2:0]          phase_o,
    output logic                err_valid_o,
    output logic [2:0]          err_code_o
);

    phase_e    phase_q;
    phase_e    nxt;
    logic      seq_err;
    logic      mode_err;
    logic      prefix_err;
    logic      entropy_err;
    logic      blk_q;
    logic      ent_q;
    logic      enter;
    err_set_t  errs;
    err_code_e code;

    hseq_phase_fsm u_fsm (
        .phase_q    (phase_q),
        .cmd        (cmd_i),
        .app_active (app_active_i),
        .absorbed   (absorbed_i),
        .perm_done  (perm_done_i),
        .escalate   (escalate_i),
        .clear_err  (clear_err_i),
        .nxt        (nxt),
        .seq_err    (seq_err)
    );

    assign enter = (phase_q == PH_IDLE) && (nxt == PH_FEED);

    hseq_cfg_check #(
        .PREFIX_W   (PREFIX_W),
        .EXP_PREFIX (EXP_PREFIX)
    ) u_cfg (
        .enter       (enter),
        .keyed_en    (keyed_en_i),
        .mode        (mode_i),
        .strength    (strength_i),
        .prefix      (prefix_i),
        .ent_ok      (ent_q),
        .mode_err    (mode_err),
        .prefix_err  (prefix_err),
        .entropy_err (entropy_err)
    );

    assign errs = '{seq: seq_err, mode: mode_err, prefix: prefix_err, entropy: entropy_err};

    hseq_err_track u_err (
        .clk           (clk),
        .rst           (rst),
        .errs          (errs),
        .allow_unsup   (allow_unsup_i),
        .err_processed (err_processed_i),
        .ready_pulse   (ent_ready_pulse_i),
        .in_idle       (phase_q == PH_IDLE),
        .blk_q         (blk_q),
        .ent_q         (ent_q),
        .err_valid     (err_valid_o),
        .err_code      (code)
    );

    // Blocked phase holds, even against escalation and clear
    always_ff @(posedge clk) begin
        if (rst)         phase_q <= PH_IDLE;
        else if (!blk_q) phase_q <= nxt;
    end

    assign phase_o    = phase_q;
    assign err_code_o = code;

endmodule

// File: rtl/hseq_checker_sva.sv
module hseq_checker_sva (
    input logic       clk,
    input logic       rst,
    input logic [2:0] cmd_i,
    input logic [3:0] absorbed_i,
    input logic [3:0] escalate_i,
    input logic [3:0] clear_err_i,
    input logic       err_processed_i,
    input logic [2:0] phase_o,
    input logic       err_valid_o,
    input logic [2:0] err_code_o,
    input logic       blk_q
);

    // R1
    reset_idle_chk: assert property (@(posedge clk) rst |=> phase_o == 3'd0);

    // R4
    abs_start_seq_chk: assert property (@(posedge clk) disable iff (rst)
        (phase_o == 3'd3 && cmd_i == 3'd1) |-> err_code_o == 3'd1);

    // R8
    freeze_chk: assert property (@(posedge clk) disable iff (rst)
        blk_q |=> phase_o == $past(phase_o));

    // R8
    release_chk: assert property (@(posedge clk) disable iff (rst)
        err_processed_i |=> !blk_q);

    // R10
    esc_term_chk: assert property (@(posedge clk) disable iff (rst)
        (!blk_q && escalate_i != 4'h9) |=> phase_o == 3'd5);

    // R2
    proc_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (phase_o == 3'd2 && absorbed_i != 4'h6 && escalate_i == 4'h9 &&
         clear_err_i != 4'h6) |=> phase_o == 3'd2);

    // R12
    valid_code_chk: assert property (@(posedge clk) disable iff (rst)
        err_valid_o == (err_code_o != 3'd0));

endmodule

bind hseq_checker hseq_checker_sva u_sva (
    .clk             (clk),
    .rst             (rst),
    .cmd_i           (cmd_i),
    .absorbed_i      (absorbed_i),
    .escalate_i      (escalate_i),
    .clear_err_i     (clear_err_i),
    .err_processed_i (err_processed_i),
    .phase_o         (phase_o),
    .err_valid_o     (err_valid_o),
    .err_code_o      (err_code_o),
    .blk_q           (blk_q)
);

// File: tb/tb_hseq_checker.sv
module tb_hseq_checker;

    localparam logic [47:0] GOOD_PFX = 48'h4341_4D4B_2001;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  cmd_i = 3'd0;
    logic        app_active_i = 1'b0;
    logic        keyed_en_i = 1'b0;
    logic [1:0]  mode_i = 2'd0;
    logic [2:0]  strength_i = 3'd2;
    logic [47:0] prefix_i = GOOD_PFX;
    logic        allow_unsup_i = 1'b0;
    logic        ent_ready_pulse_i = 1'b0;
    logic        err_processed_i = 1'b0;
    logic [3:0]  absorbed_i = 4'h9;
    logic        perm_done_i = 1'b0;
    logic [3:0]  escalate_i = 4'h9;
    logic [3:0]  clear_err_i = 4'h9;
    logic [2:0]  phase_o;
    logic        err_valid_o;
    logic [2:0]  err_code_o;

    int n_chk = 0;
    int n_bad = 0;
    logic       cap_v;
    logic [2:0] cap_code;

    always #5 clk = ~clk;

    hseq_checker dut (
        .clk(clk), .rst(rst), .cmd_i(cmd_i), .app_active_i(app_active_i),
        .keyed_en_i(keyed_en_i), .mode_i(mode_i), .strength_i(strength_i),
        .prefix_i(prefix_i), .allow_unsup_i(allow_unsup_i),
        .ent_ready_pulse_i(ent_ready_pulse_i), .err_processed_i(err_processed_i),
        .absorbed_i(absorbed_i), .perm_done_i(perm_done_i), .escalate_i(escalate_i),
        .clear_err_i(clear_err_i), .phase_o(phase_o), .err_valid_o(err_valid_o),
        .err_code_o(err_code_o)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // inputs are set at a falling edge; capture combinational outputs, then cross one edge
    task automatic apply(input logic [2:0] c);
        cmd_i = c;
        #1;
        cap_v    = err_valid_o;
        cap_code = err_code_o;
        @(negedge clk);
        cmd_i = 3'd0;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        cmd_i = 3'd0; app_active_i = 1'b0; keyed_en_i = 1'b0; mode_i = 2'd0;
        strength_i = 3'd2; prefix_i = GOOD_PFX; allow_unsup_i = 1'b0;
        ent_ready_pulse_i = 1'b0; err_processed_i = 1'b0; absorbed_i = 4'h9;
        perm_done_i = 1'b0; escalate_i = 4'h9; clear_err_i = 4'h9;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic goto(input int p);
        do_reset();
        if (p >= 1) apply(3'd1);
        if (p >= 2) apply(3'd2);
        if (p >= 3) begin absorbed_i = 4'h6; apply(3'd0); absorbed_i = 4'h9; end
        if (p >= 4) apply(3'd3);
    endtask

    function automatic bit legal(input int p, input int c);
        case (p)
            0: return c <= 1;
            1: return c == 0 || c == 2;
            3: return c == 0 || c == 3 || c == 4;
            default: return c == 0;
        endcase
    endfunction

    function automatic int next_ph(input int p, input int c);
        case (p)
            0: return (c == 1) ? 1 : 0;
            1: return (c == 2) ? 2 : 1;
            3: return (c == 3) ? 4 : (c == 4) ? 0 : 3;
            default: return p;
        endcase
    endfunction

    initial begin
        #2_000_000;
        n_bad++;
        $display("FAIL watchdog: actual 0 expected 1");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        @(negedge clk);
        do_reset();
        // R1 reset state
        chk("R1 phase", int'(phase_o), 0);
        chk("R1 valid", int'(err_valid_o), 0);
        chk("R1 code", int'(err_code_o), 0);

        // R4 R2 sweep of every command in every working phase
        for (int p = 0; p < 5; p++) begin
            for (int c = 0; c < 8; c++) begin
                goto(p);
                apply(3'(c));
                chk("R4 code", int'(cap_code), legal(p, c) ? 0 : 1);
                chk("R2 next phase", int'(phase_o), next_ph(p, c));
            end
        end

        // R2 processing needs exact true, squeezing returns on perm done
        goto(2);
        absorbed_i = 4'h7; apply(3'd0); absorbed_i = 4'h9;
        chk("R2 loose absorbed holds", int'(phase_o), 2);
        goto(4);
        perm_done_i = 1'b1; apply(3'd0); perm_done_i = 1'b0;
        chk("R2 perm done", int'(phase_o), 3);

        // R5 sweep of mode and strength pairs
        for (int m = 0; m < 4; m++) begin
            for (int s = 0; s < 8; s++) begin
                bit ok;
                ok = (m == 0 && s >= 1 && s <= 4) || ((m == 1 || m == 2) && (s == 0 || s == 2));
                do_reset();
                mode_i = 2'(m); strength_i = 3'(s);
                apply(3'd1);
                chk("R5 code", int'(cap_code), ok ? 0 : 2);
                chk("R5 phase", int'(phase_o), 1);
            end
        end

        // R3 start while application active
        do_reset();
        app_active_i = 1'b1; apply(3'd1); app_active_i = 1'b0;
        chk("R3 phase", int'(phase_o), 0);
        chk("R3 valid", int'(cap_v), 0);

        // R8 sequence error freezes until acknowledge
        goto(1);
        apply(3'd1);
        chk("R8 seq code", int'(cap_code), 1);
        apply(3'd2);
        chk("R8 frozen", int'(phase_o), 1);
        err_processed_i = 1'b1; apply(3'd0); err_processed_i = 1'b0;
        apply(3'd2);
        chk("R8 released", int'(phase_o), 2);

        // R8 unsupported pair blocks only when not allowed
        do_reset();
        mode_i = 2'd3; apply(3'd1); apply(3'd2);
        chk("R8 mode blocks", int'(phase_o), 1);
        do_reset();
        mode_i = 2'd3; allow_unsup_i = 1'b1; apply(3'd1); apply(3'd2);
        chk("R8 mode allowed", int'(phase_o), 2);

        // R7 entropy flag absent
        do_reset();
        keyed_en_i = 1'b1; apply(3'd1);
        chk("R7 entropy code", int'(cap_code), 4);
        apply(3'd2);
        chk("R7 entropy blocks", int'(phase_o), 1);

        // R7 flag set in idle, no error
        do_reset();
        keyed_en_i = 1'b1;
        ent_ready_pulse_i = 1'b1; apply(3'd0); ent_ready_pulse_i = 1'b0;
        apply(3'd1);
        chk("R7 flag set", int'(cap_code), 0);

        // R7 acknowledge clears the flag
        do_reset();
        keyed_en_i = 1'b1;
        ent_ready_pulse_i = 1'b1; apply(3'd0); ent_ready_pulse_i = 1'b0;
        err_processed_i = 1'b1; apply(3'd0); err_processed_i = 1'b0;
        apply(3'd1);
        chk("R7 flag cleared", int'(cap_code), 4);

        // R7 pulse outside idle is ignored
        goto(1);
        keyed_en_i = 1'b1;
        ent_ready_pulse_i = 1'b1; apply(3'd0); ent_ready_pulse_i = 1'b0;
        apply(3'd2);
        absorbed_i = 4'h6; apply(3'd0); absorbed_i = 4'h9;
        apply(3'd4);
        chk("R7 back to idle", int'(phase_o), 0);
        apply(3'd1);
        chk("R7 pulse outside idle", int'(cap_code), 4);

        // R6 prefix error does not block
        do_reset();
        keyed_en_i = 1'b1; prefix_i = 48'h1;
        ent_ready_pulse_i = 1'b1; apply(3'd0); ent_ready_pulse_i = 1'b0;
        apply(3'd1);
        chk("R6 prefix code", int'(cap_code), 3);
        apply(3'd2);
        chk("R6 no block", int'(phase_o), 2);
        // R6 prefix ignored when unkeyed
        do_reset();
        prefix_i = 48'h1; apply(3'd1);
        chk("R6 unkeyed", int'(cap_code), 0);

        // R9 priorities
        do_reset();
        keyed_en_i = 1'b1; prefix_i = 48'h1; mode_i = 2'd3; apply(3'd1);
        chk("R9 mode over prefix", int'(cap_code), 2);
        do_reset();
        keyed_en_i = 1'b1; prefix_i = 48'h1; apply(3'd1);
        chk("R9 prefix over entropy", int'(cap_code), 3);

        // R12 single-cycle pulse
        goto(2);
        apply(3'd5);
        chk("R12 valid high", int'(cap_v), 1);
        apply(3'd0);
        chk("R12 valid low", int'(cap_v), 0);
        chk("R12 code none", int'(cap_code), 0);

        // R10 escalation, R11 clear
        goto(3);
        escalate_i = 4'h3; apply(3'd0); escalate_i = 4'h9;
        chk("R10 terminal", int'(phase_o), 5);
        apply(3'd0);
        chk("R10 stays", int'(phase_o), 5);
        clear_err_i = 4'h7; apply(3'd0);
        chk("R11 loose clear", int'(phase_o), 5);
        clear_err_i = 4'h6; apply(3'd0); clear_err_i = 4'h9;
        chk("R11 clear to idle", int'(phase_o), 0);
        goto(1);
        clear_err_i = 4'h6; apply(3'd0); clear_err_i = 4'h9;
        chk("R11 feed to idle", int'(phase_o), 0);
        goto(4);
        clear_err_i = 4'h6; escalate_i = 4'h0; apply(3'd0);
        clear_err_i = 4'h9; escalate_i = 4'h9;
        chk("R10 escalation beats clear", int'(phase_o), 5);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule